// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

The block is an 8-bit down-counter fed by a 6-bit prescaler. Every prescaler terminal step moves the counter down by one. When the count runs out, the block raises a one-cycle interrupt pulse and toggles its square-wave output. After that the counter either stops at zero or reloads its initial value and keeps going. Software sets it up through a small write port: an initial-value register, a prescaler register, a control register and an input-mode register. The current count can be read at any time on `rd_data` without disturbing it.

The count steps come from one of three sources. The first is the system clock divided by four. The second is the rising edges of the external input `ext_in`, taken through a two-flop synchroniser. The third is the end-of-count pulse of a neighbouring timer (`cascade_in`), which chains the two counters. When the internal source is selected, the external input can instead gate the internal ticks. It can also act as a trigger, where a falling edge reloads the counter and starts a pass, in a retriggerable or a non-retriggerable flavour.

Register map: address 0 holds the initial value. Address 1 holds the prescaler: bits [7:2] are the division code, bit 1 selects the internal source (1) or the external edge source (0), and bit 0 selects modulo-n (1) or single-pass (0). Address 2 is control: bit 0 is a load command and bit 1 is the enable bit. Address 3 is the input mode: bits [1:0] are 00 clock, 01 gate, 10 non-retriggerable trigger and 11 retriggerable trigger, and bit 2 selects the cascade source.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, `rd_data` is 0, `eoc_irq` is 0 and `tout` is 0.
- R2: The prescaler passes one counter step per N source ticks, where N is the code in bits [7:2] of address 1 (1 to 63), and code 0 means 64. With the internal source this gives an end-of-count period of 4·N·M clock cycles.
- R3: The counter counts M steps per pass, where M is the initial value (1 to 255), and value 0 means 256. Between loads and triggers, the count changes only by stepping down by one or by reloading the initial value.
- R4: At end of count (a step taken when the count is 1), `eoc_irq` is high for one cycle and `tout` toggles. `tout` changes at no other time.
- R5: In single-pass mode (address 1 bit 0 = 0), the counter stops at 0 after end of count and raises no further pulse. In modulo-n mode (bit 0 = 1), it reloads the initial value and continues.
- R6: Writing address 2 with bit 0 set copies the initial value and the prescaler code into the counter and prescaler. Bit 1 enables counting. While disabled the count holds, and re-enabling without a load continues from the held count. Writing address 0 alone does not change the count.
- R7: With address 1 bit 1 = 1, the source ticks once every four clock cycles. With bit 1 = 0 and mode bits 00, each rising edge of `ext_in` is one tick, seen after two synchronising flops.
- R8: In gate mode (address 3 bits [1:0] = 01, internal source), internal ticks are counted only while `ext_in` is high.
- R9: In trigger modes (bits [1:0] = 10 or 11, internal source), a load waits for a trigger, and a falling edge of `ext_in` reloads the counter and starts a pass. Mode 10 ignores falling edges during an active pass. Mode 11 reloads on every falling edge.
- R10: With address 3 bit 2 = 1, each cycle in which `cascade_in` is high is one source tick, whatever the other source settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| ext_in | input | 1 | External clock, gate or trigger input (asynchronous) |
| cascade_in | input | 1 | End-of-count pulse from a neighbouring timer |
| rd_data | output | 8 | Current count |
| eoc_irq | output | 1 | One-cycle end-of-count pulse |
| tout | output | 1 | Output that toggles at each end of count |

## Verification
The hardest situation to reach is a second falling trigger edge that lands inside a pass already under way. Reaching it needs the synchroniser delay, the divide-by-four phase and the prescaler to line up so that the pass is provably still running. The stimulus loads a trigger mode with a long initial value and a prescaler code of 1. It then drops `ext_in` once, raises it, and drops it again a few cycles later. A per-cycle reference model decides whether that second edge must reload the counter (mode 11) or be ignored (mode 10). The wrap cases of code 0 and value 0 are reached by timing the distance between two successive interrupt pulses, which must be exactly 256 and 1024 cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    parameter int CNT_W = 8;
    parameter int PRE_W = 6;

    typedef struct packed {
        logic [CNT_W-1:0] init;
        logic [PRE_W-1:0] code;
        logic             modulo;
        logic             int_src;
        logic             casc;
        logic             en;
        logic [1:0]       mode;
    } cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [PRE_W-1:0] pre;
        logic             run;
        logic             irq;
        logic             tout;
    } core_t;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl,
    output logic prev
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign lvl  = sh_q[STAGES-1];
    assign prev = sh_q[STAGES];
endmodule

// File: rtl/tmr_tick.sv
module tmr_tick #(
    parameter int DIV_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  logic       prev,
    input  logic       cascade_in,
    input  logic       int_src,
    input  logic       casc,
    input  logic [1:0] mode,
    output logic       tick,
    output logic       trig_mode,
    output logic       fall
);
    logic [DIV_W-1:0] div_d, div_q;
    logic             int_tick;
    logic             gate_mode;

    always_comb begin
        div_d     = div_q + {{(DIV_W-1){1'b0}}, 1'b1};
        int_tick  = &div_q;
        gate_mode = int_src && !casc && (mode == 2'b01);
        trig_mode = int_src && !casc && mode[1];
        fall      = prev && !lvl;
        if (casc)         tick = cascade_in;
        else if (int_src) tick = int_tick && (!gate_mode || lvl);
        else              tick = lvl && !prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             en,
    input  logic             trig_mode,
    input  logic             retrig,
    input  logic             fall,
    input  logic             tick,
    input  logic             modulo,
    input  logic [CNT_W-1:0] init,
    input  logic [PRE_W-1:0] code,
    output logic [CNT_W-1:0] count,
    output logic             irq,
    output logic             tout,
    output logic             fire
);
    localparam logic [CNT_W-1:0] CNT_ONE = 1;
    localparam logic [PRE_W-1:0] PRE_ONE = 1;

    core_t d, q;

    assign fire = !load && en && trig_mode && fall && (!q.run || retrig);

    always_comb begin
        d     = q;
        d.irq = 1'b0;
        if (load) begin
            d.count = init;
            d.pre   = code;
            d.run   = !trig_mode;
        end else if (fire) begin
            d.count = init;
            d.pre   = code;
            d.run   = 1'b1;
        end else if (en && q.run && tick) begin
            if (q.pre == PRE_ONE) begin
                d.pre = code;
                if (q.count == CNT_ONE) begin
                    d.irq  = 1'b1;
                    d.tout = !q.tout;
                    if (modulo) begin
                        d.count = init;
                    end else begin
                        d.count = '0;
                        d.run   = 1'b0;
                    end
                end else begin
                    d.count = q.count - CNT_ONE;
                end
            end else begin
                d.pre = q.pre - PRE_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count = q.count;
    assign irq   = q.irq;
    assign tout  = q.tout;
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ext_in,
    input  logic             cascade_in,
    output logic [CNT_W-1:0] rd_data,
    output logic             eoc_irq,
    output logic             tout
);
    cfg_t cfg_d, cfg_q;
    logic load_stb;
    logic lvl, prev;
    logic tick, trig_mode, fall, trig_fire;
    logic cfg_en;
    logic [CNT_W-1:0] cfg_init;

    always_comb begin
        cfg_d    = cfg_q;
        load_stb = wr_en && (wr_addr == 2'd2) && wr_data[0];
        if (wr_en) begin
            case (wr_addr)
                2'd0: cfg_d.init = wr_data;
                2'd1: begin
                    cfg_d.code    = wr_data[PRE_W+1:2];
                    cfg_d.int_src = wr_data[1];
                    cfg_d.modulo  = wr_data[0];
                end
                2'd2: cfg_d.en = wr_data[1];
                default: begin
                    cfg_d.mode = wr_data[1:0];
                    cfg_d.casc = wr_data[2];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_en   = cfg_q.en;
    assign cfg_init = cfg_q.init;

    tmr_sync #(.STAGES(2)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_in),
        .lvl      (lvl),
        .prev     (prev)
    );

    tmr_tick #(.DIV_W(2)) i_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (lvl),
        .prev       (prev),
        .cascade_in (cascade_in),
        .int_src    (cfg_q.int_src),
        .casc       (cfg_q.casc),
        .mode       (cfg_q.mode),
        .tick       (tick),
        .trig_mode  (trig_mode),
        .fall       (fall)
    );

    tmr_core i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_stb),
        .en        (cfg_q.en),
        .trig_mode (trig_mode),
        .retrig    (cfg_q.mode[0]),
        .fall      (fall),
        .tick      (tick),
        .modulo    (cfg_q.modulo),
        .init      (cfg_q.init),
        .code      (cfg_q.code),
        .count     (rd_data),
        .irq       (eoc_irq),
        .tout      (tout),
        .fire      (trig_fire)
    );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] count,
    input logic         irq,
    input logic         tout,
    input logic         en,
    input logic         load,
    input logic         fire,
    input logic [W-1:0] init
);
    localparam logic [W-1:0] ONE = 1;

    AST_EOC_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(count) == ONE)); // R4

    AST_TOUT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (tout != $past(tout))); // R4

    AST_TOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> $stable(tout)); // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && !$past(fire) && (count != $past(count)))
        |-> ((count == $past(count) - ONE) || (count == $past(init)))); // R3

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> (count == $past(init))); // R6

    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(en) && !$past(load)) |-> $stable(count)); // R6

    AST_TRIGGER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fire) |-> (count == $past(init))); // R9
endmodule

bind prescaled_timer tmr_checker #(.W(8)) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .count (rd_data),
    .irq   (eoc_irq),
    .tout  (tout),
    .en    (cfg_en),
    .load  (load_stb),
    .fire  (trig_fire),
    .init  (cfg_init)
);

// File: tb/test_prescaled_timer.sv
module test_prescaled_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       ext_in = 1'b0;
    logic       cascade_in = 1'b0;
    logic [7:0] rd_data;
    logic       eoc_irq;
    logic       tout;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    prescaled_timer i_prescaled_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_in(ext_in), .cascade_in(cascade_in),
        .rd_data(rd_data), .eoc_irq(eoc_irq), .tout(tout)
    );

    // behavioural reference model
    int m_div, s1, s2, s3, m_count, m_pre, m_run, m_en, m_irq, m_tout;
    int m_init, m_code, m_modulo, m_int, m_mode, m_casc;

    always @(posedge clk) begin
        int tk, trig, fall, ld;
        if (!rst_n) begin
            m_div = 0; s1 = 0; s2 = 0; s3 = 0; m_count = 0; m_pre = 0;
            m_run = 0; m_en = 0; m_irq = 0; m_tout = 0; m_init = 0;
            m_code = 0; m_modulo = 0; m_int = 0; m_mode = 0; m_casc = 0;
        end else begin
            if (m_casc != 0) tk = int'(cascade_in);
            else if (m_int != 0) tk = (m_div == 3 && (m_mode != 1 || s2 == 1)) ? 1 : 0;
            else tk = (s2 == 1 && s3 == 0) ? 1 : 0;
            trig = (m_casc == 0 && m_int != 0 && m_mode >= 2) ? 1 : 0;
            fall = (s3 == 1 && s2 == 0) ? 1 : 0;
            ld = (wr_en && wr_addr == 2'd2 && wr_data[0]) ? 1 : 0;
            m_irq = 0;
            if (ld != 0) begin
                m_count = m_init; m_pre = m_code; m_run = (trig != 0) ? 0 : 1;
            end else if (m_en != 0 && trig != 0 && fall != 0 && (m_run == 0 || m_mode == 3)) begin
                m_count = m_init; m_pre = m_code; m_run = 1;
            end else if (m_en != 0 && m_run != 0 && tk != 0) begin
                if (m_pre == 1) begin
                    m_pre = m_code;
                    if (m_count == 1) begin
                        m_irq = 1; m_tout = 1 - m_tout;
                        if (m_modulo != 0) m_count = m_init;
                        else begin m_count = 0; m_run = 0; end
                    end else m_count = (m_count + 255) % 256;
                end else m_pre = (m_pre + 63) % 64;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_init = int'(wr_data);
                    2'd1: begin m_code = int'(wr_data[7:2]); m_int = int'(wr_data[1]); m_modulo = int'(wr_data[0]); end
                    2'd2: m_en = int'(wr_data[1]);
                    default: begin m_mode = int'(wr_data[1:0]); m_casc = int'(wr_data[2]); end
                endcase
            end
            s3 = s2; s2 = s1; s1 = int'(ext_in);
            m_div = (m_div + 1) % 4;
        end
    end

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cyc > 2) begin
            chk(int'(rd_data) == m_count, {tag, " model count"}, int'(rd_data), m_count);
            chk(int'(eoc_irq) == m_irq, {tag, " model irq"}, int'(eoc_irq), m_irq);
            chk(int'(tout) == m_tout, {tag, " model tout"}, int'(tout), m_tout);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] dat);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = dat;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (eoc_irq) break;
        end
    endtask

    task automatic gap(input int exp, input string t);
        int n;
        logic t0;
        wait_irq();
        t0 = tout;
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk); n++;
            if (eoc_irq) break;
        end
        chk(n == exp, {t, " period"}, n, exp);
        chk(tout != t0, "R4 tout toggle", int'(tout), int'(!t0));
    endtask

    task automatic pulse_ext(input int hi, input int lo);
        @(negedge clk); ext_in = 1'b1; idle(hi);
        ext_in = 1'b0; idle(lo);
    endtask

    initial begin
        int c, n;
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data == 8'd0, "R1 count", int'(rd_data), 0);
        chk(eoc_irq == 1'b0, "R1 irq", int'(eoc_irq), 0);
        chk(tout == 1'b0, "R1 tout", int'(tout), 0);

        tag = "R2";
        wr(2'd1, 8'h0F); wr(2'd0, 8'd2); wr(2'd3, 8'd0); wr(2'd2, 8'd3);
        gap(24, "R2 code3 init2");
        wr(2'd1, 8'h03); wr(2'd0, 8'd1); wr(2'd2, 8'd3);
        gap(256, "R2 code0 means 64");

        tag = "R3";
        wr(2'd1, 8'h07); wr(2'd0, 8'd0); wr(2'd2, 8'd3);
        gap(1024, "R3 init0 means 256");

        tag = "R5";
        wr(2'd1, 8'h06); wr(2'd0, 8'd3); wr(2'd2, 8'd3);
        wait_irq();
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (eoc_irq) n++;
        end
        chk(n == 0, "R5 single-pass no more pulses", n, 0);
        chk(rd_data == 8'd0, "R5 single-pass stops at zero", int'(rd_data), 0);

        tag = "R6";
        wr(2'd1, 8'h07); wr(2'd0, 8'd200); wr(2'd2, 8'd3);
        idle(40);
        wr(2'd2, 8'd0);
        c = int'(rd_data);
        idle(30);
        chk(int'(rd_data) == c, "R6 hold while disabled", int'(rd_data), c);
        wr(2'd0, 8'd5);
        chk(int'(rd_data) == c, "R6 init write without load", int'(rd_data), c);
        wr(2'd2, 8'd2);
        idle(8);
        chk(int'(rd_data) < c && int'(rd_data) > c - 4, "R6 continue from held count", int'(rd_data), c - 2);

        tag = "R7";
        wr(2'd2, 8'd0); wr(2'd1, 8'h05); wr(2'd0, 8'd3); wr(2'd2, 8'd3);
        idle(20);
        chk(rd_data == 8'd3, "R7 external no edges", int'(rd_data), 3);
        pulse_ext(3, 3); pulse_ext(3, 3);
        idle(4);
        chk(rd_data == 8'd1, "R7 two edges counted", int'(rd_data), 1);
        pulse_ext(3, 6);

        tag = "R8";
        wr(2'd2, 8'd0); wr(2'd1, 8'h07); wr(2'd3, 8'd1); wr(2'd0, 8'd100); wr(2'd2, 8'd3);
        idle(20);
        chk(rd_data == 8'd100, "R8 gate low blocks", int'(rd_data), 100);
        ext_in = 1'b1;
        idle(20);
        chk(rd_data < 8'd100, "R8 gate high counts", int'(rd_data), 96);

        tag = "R9";
        wr(2'd2, 8'd0); wr(2'd3, 8'd2); wr(2'd1, 8'h06); wr(2'd0, 8'd20); wr(2'd2, 8'd3);
        idle(20);
        chk(rd_data == 8'd20, "R9 waits for trigger", int'(rd_data), 20);
        ext_in = 1'b0; idle(12);
        chk(rd_data < 8'd20, "R9 trigger starts pass", int'(rd_data), 18);
        ext_in = 1'b1; idle(4);
        ext_in = 1'b0; idle(6);
        chk(rd_data < 8'd18, "R9 non-retriggerable ignores edge", int'(rd_data), 15);
        ext_in = 1'b1;
        wr(2'd3, 8'd3); wr(2'd2, 8'd3);
        ext_in = 1'b0; idle(20);
        ext_in = 1'b1; idle(4);
        ext_in = 1'b0; idle(4);
        chk(rd_data >= 8'd19, "R9 retriggerable reloads", int'(rd_data), 19);

        tag = "R10";
        wr(2'd2, 8'd0); wr(2'd3, 8'd4); wr(2'd1, 8'h07); wr(2'd0, 8'd4); wr(2'd2, 8'd3);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); cascade_in = 1'b1;
            @(negedge clk); cascade_in = 1'b0;
            ext_in = ~ext_in;
            idle(3);
        end
        chk(rd_data == 8'd1, "R10 cascade pulses counted", int'(rd_data), 1);
        idle(5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule